// File: doc/BRIEF.md
# Software Interrupt IO Port Trap

This block sits on a simple host IO bus and turns a byte write to a fixed command port into a System Management Interrupt request for the processor. The byte written there is kept as a command number, and a neighbouring parameter port keeps a second byte for the handler without raising anything. Firmware reads both bytes back over the same bus, and it controls the trap through a small control and status port.

Trapping is gated by an enable bit. Once a request is raised it stays raised, and is shown as a sticky pending bit, until firmware writes a one to the clear bit. Every address compare uses all 16 address bits, and only write cycles change state. All three ports are parameters: command port `0x00B2`, parameter port `0x00B3`, control/status port `0x00B8`.

Top module: `smi_port_trap`

## Requirements
- R1: With the enable bit set, a write cycle (`io_valid`=1, `io_write`=1) to the command port sets the pending bit, and `smi_req` is 1 from the clock edge that takes the write.
- R2: Every write to the command port loads its data byte into `cmd_value` at that clock edge, whether or not trapping is enabled.
- R3: A write to the parameter port loads `param_value`. It never sets the pending bit and never changes `smi_req`.
- R4: With the enable bit clear, a write to the command port still loads the byte but leaves `smi_req` at 0.
- R5: Once set, the pending bit and `smi_req` stay 1 until a control-port write with bit 1 = 1. That write clears both at its clock edge. A control-port write with bit 1 = 0 leaves them unchanged.
- R6: A command-port write while a request is pending overwrites `cmd_value`, and `smi_req` stays 1.
- R7: During a read cycle (`io_valid`=1, `io_write`=0), `io_rdata` gives the latched command byte for the command port and the latched parameter byte for the parameter port. For the control port it gives bit 0 = enable and bit 1 = pending, with the other bits 0. Any other address, and any cycle that is not a read, gives 0. The result is combinational.
- R8: A synchronous reset sets `cmd_value`, `param_value`, the enable bit, the pending bit and `smi_req` to 0.
- R9: The address compare covers all 16 bits, so an address such as `0x01B2` is ignored. Read cycles, and cycles with `io_valid`=0, change no state.
- R10: A control-port write sets the enable bit from data bit 0. Clearing the enable bit does not cancel a pending request. Setting it does not raise a request by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | An IO cycle is present this clock |
| io_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| io_addr | input | 16 | IO port address |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte (combinational) |
| smi_req | output | 1 | Interrupt request, held until cleared |
| cmd_value | output | 8 | Latched command byte |
| param_value | output | 8 | Latched parameter byte |

## Verification
The hardest case to reach is a second command write that lands while the first request is still pending. It has to overwrite the command byte without dropping or re-pulsing the request. The stimulus gets there by enabling the trap, raising a request, and then writing a new command, a write with the clear bit at 0, a disable, and addresses that alias in the low byte, all before any clear is sent. The request is then cleared while disabled, to show that re-enabling raises nothing.

// File: rtl/smi_trap_pkg.sv
package smi_trap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // bit positions inside the control/status byte
    localparam int CSR_EN_BIT  = 0;
    localparam int CSR_CLR_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CMD   = 2'd1,
        SEL_PARAM = 2'd2,
        SEL_CSR   = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic en;
        logic pend;
    } trap_state_t;

    function automatic port_sel_e match_port(
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] cmd_port,
        input logic [ADDR_W-1:0] param_port,
        input logic [ADDR_W-1:0] csr_port
    );
        if (addr == cmd_port)   return SEL_CMD;
        if (addr == param_port) return SEL_PARAM;
        if (addr == csr_port)   return SEL_CSR;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/smi_io_decode.sv
module smi_io_decode
    import smi_trap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_PORT   = 16'h00B2,
    parameter logic [ADDR_W-1:0] PARAM_PORT = 16'h00B3,
    parameter logic [ADDR_W-1:0] CSR_PORT   = 16'h00B8
) (
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output port_sel_e         wr_sel,
    output port_sel_e         rd_sel
);
    port_sel_e hit;

    always_comb begin
        hit    = match_port(io_addr, CMD_PORT, PARAM_PORT, CSR_PORT);
        wr_sel = (io_valid && io_write)  ? hit : SEL_NONE;
        rd_sel = (io_valid && !io_write) ? hit : SEL_NONE;
    end
endmodule

// File: rtl/smi_byte_latch.sv
module smi_byte_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    // R2
    load_takes_data_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));
endmodule

// File: rtl/smi_trap_ctrl.sv
module smi_trap_ctrl
    import smi_trap_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  port_sel_e        wr_sel,
    input  logic [WIDTH-1:0] wdata,
    output trap_state_t      state
);
    trap_state_t nxt;
    logic        do_clear;
    logic        do_raise;

    always_comb begin
        do_clear = (wr_sel == SEL_CSR) && wdata[CSR_CLR_BIT];
        do_raise = (wr_sel == SEL_CMD) && state.en;
        nxt      = state;
        if (wr_sel == SEL_CSR) nxt.en = wdata[CSR_EN_BIT];
        if (do_clear)          nxt.pend = 1'b0;
        else if (do_raise)     nxt.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state.pend && !(wr_sel == SEL_CSR && wdata[CSR_CLR_BIT])) |=> state.pend);

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_CSR && wdata[CSR_CLR_BIT]) |=> !state.pend);

    // R3
    param_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_PARAM && !state.pend) |=> !state.pend);

    // R10
    enable_alone_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == SEL_CSR && !state.pend) |=> !state.pend);
endmodule

// File: rtl/smi_port_trap.sv
module smi_port_trap
    import smi_trap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CMD_PORT   = 16'h00B2,
    parameter logic [ADDR_W-1:0] PARAM_PORT = 16'h00B3,
    parameter logic [ADDR_W-1:0] CSR_PORT   = 16'h00B8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              smi_req,
    output logic [DATA_W-1:0] cmd_value,
    output logic [DATA_W-1:0] param_value
);
    localparam int CSR_PAD = DATA_W - 2;

    port_sel_e   wr_sel;
    port_sel_e   rd_sel;
    trap_state_t st;

    smi_io_decode #(
        .CMD_PORT  (CMD_PORT),
        .PARAM_PORT(PARAM_PORT),
        .CSR_PORT  (CSR_PORT)
    ) u_decode (
        .io_valid(io_valid),
        .io_write(io_write),
        .io_addr (io_addr),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel)
    );

    smi_byte_latch #(.WIDTH(DATA_W)) u_cmd_latch (
        .clk (clk),
        .rst (rst),
        .load(wr_sel == SEL_CMD),
        .din (io_wdata),
        .q   (cmd_value)
    );

    smi_byte_latch #(.WIDTH(DATA_W)) u_param_latch (
        .clk (clk),
        .rst (rst),
        .load(wr_sel == SEL_PARAM),
        .din (io_wdata),
        .q   (param_value)
    );

    smi_trap_ctrl #(.WIDTH(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_sel(wr_sel),
        .wdata (io_wdata),
        .state (st)
    );

    assign smi_req = st.pend;

    always_comb begin
        unique case (rd_sel)
            SEL_CMD:   io_rdata = cmd_value;
            SEL_PARAM: io_rdata = param_value;
            SEL_CSR:   io_rdata = {{CSR_PAD{1'b0}}, st.pend, st.en};
            default:   io_rdata = '0;
        endcase
    end

    // R1
    rise_from_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(smi_req) |-> $past(io_valid && io_write && io_addr == CMD_PORT));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!smi_req && cmd_value == '0 && param_value == '0));

    // R6
    overwrite_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
        (smi_req && io_valid && io_write && io_addr == CMD_PORT) |=> smi_req);

    // R7
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !io_valid |-> (io_rdata == '0));
endmodule

// File: tb/smi_port_trap_bench.sv
`timescale 1ns/1ps
module smi_port_trap_bench;

    localparam logic [15:0] CMDP = 16'h00B2;
    localparam logic [15:0] PARP = 16'h00B3;
    localparam logic [15:0] CSRP = 16'h00B8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        smi_req;
    logic [7:0]  cmd_value;
    logic [7:0]  param_value;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit       m_en, m_pend;
    bit [7:0] m_cmd, m_par;

    always #10 clk = ~clk;

    smi_port_trap u_smi_port_trap (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .smi_req(smi_req), .cmd_value(cmd_value), .param_value(param_value)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [7:0] model_read(bit v, bit w, bit [15:0] a);
        if (!v || w) return 8'h00;
        case (a)
            CMDP:    return m_cmd;
            PARP:    return m_par;
            CSRP:    return {6'b0, m_pend, m_en};
            default: return 8'h00;
        endcase
    endfunction

    // one bus clock: compare registered outputs, drive, compare read data, update model
    task automatic step(input string req, input bit r, input bit v, input bit w,
                        input bit [15:0] a, input bit [7:0] d);
        @(negedge clk);
        check(req, "smi_req", smi_req, m_pend);
        check(req, "cmd_value", cmd_value, m_cmd);
        check(req, "param_value", param_value, m_par);
        rst = r; io_valid = v; io_write = w; io_addr = a; io_wdata = d;
        #1;
        check(req, "io_rdata", io_rdata, r ? io_rdata : model_read(v, w, a));
        @(posedge clk);
        if (r) begin
            m_en = 0; m_pend = 0; m_cmd = 0; m_par = 0;
        end else if (v && w) begin
            case (a)
                CMDP: begin m_cmd = d; if (m_en) m_pend = 1; end
                PARP: m_par = d;
                CSRP: begin m_en = d[0]; if (d[1]) m_pend = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic wr(input string req, input bit [15:0] a, input bit [7:0] d);
        step(req, 0, 1, 1, a, d);
    endtask

    task automatic rd(input string req, input bit [15:0] a);
        step(req, 0, 1, 0, a, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8 reset state
        step("R8", 1, 0, 0, 0, 0);
        step("R8", 1, 1, 1, CMDP, 8'hAA);
        step("R8", 0, 0, 0, 0, 0);
        rd("R7", CSRP);
        // R4 disabled: latched, no request
        wr("R4", CMDP, 8'h11);
        rd("R2", CMDP);
        rd("R4", CSRP);
        // R10 enable, R3 parameter
        wr("R10", CSRP, 8'h01);
        wr("R3", PARP, 8'h5A);
        rd("R3", PARP);
        rd("R7", 16'h00B4);
        // R1 raise
        wr("R1", CMDP, 8'h22);
        rd("R1", CSRP);
        // R6 overwrite while pending
        wr("R6", CMDP, 8'h33);
        wr("R3", PARP, 8'h66);
        // R9 aliases, reads and idle cycles change nothing
        wr("R9", 16'h01B2, 8'h77);
        wr("R9", 16'h80B3, 8'h78);
        wr("R9", 16'hB200, 8'h79);
        rd("R9", CMDP);
        step("R9", 0, 0, 1, CMDP, 8'h7A);
        step("R9", 0, 0, 1, CSRP, 8'h02);
        // R5 write without clear bit keeps request
        wr("R5", CSRP, 8'h01);
        wr("R5", CSRP, 8'hFD);
        // R10 disable keeps pending, clear while disabled, re-enable raises nothing
        wr("R10", CSRP, 8'h00);
        rd("R10", CSRP);
        wr("R5", CSRP, 8'h02);
        wr("R10", CSRP, 8'h01);
        rd("R10", CSRP);
        // R1/R5 repeated raise and clear across values
        for (int i = 0; i < 6; i++) begin
            wr("R1", CMDP, 8'(i * 37 + 3));
            rd("R2", CMDP);
            wr("R5", CSRP, 8'h03);
        end
        // R5 clear and command in adjacent cycles
        wr("R6", CMDP, 8'hC1);
        wr("R5", CSRP, 8'h02);
        wr("R4", CMDP, 8'hC2);
        // R8 reset mid-run
        wr("R3", PARP, 8'hEE);
        step("R8", 1, 0, 0, 0, 0);
        rd("R8", CSRP);
        rd("R8", PARP);
        wr("R4", CMDP, 8'h44);
        step("R8", 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule